// File: doc/BRIEF.md
# MDIO Management Frame Engine

This block drives the two-wire management port of an Ethernet PHY from one packed 32-bit command word. Software builds the whole management transaction in a single word: start code, opcode, PHY address, register address, turnaround pattern and write data. Writing that word while the port is enabled and idle launches a 64-bit serial frame. The frame is 32 preamble ones followed by the word itself, sent most significant bit first. The engine makes the management clock by dividing the system clock, updates the data line on the falling clock edge and manages the tri-state enable.

On a read the engine releases the data line at the second turnaround bit. It then shifts the 16 bits returned by the PHY into the low half of the same word, so software reads the result back from where it wrote the command. Software learns that a frame has finished only from an idle flag. A port-enable input gates everything: with it low, no frame starts, and clearing it during a frame stops the frame at once.

Top module: `mdio_frame_engine`

## Requirements
- R1: The command word is laid out as follows. Bit 30 and bit 17 are written as 1. Bits 29:28 hold the opcode (2'b10 = read, 2'b01 = write). Bits 27:23 hold the PHY address, bits 22:18 the register address, and bits 15:0 the write data. An accepted frame on `mdio_o` is 32 ones followed by word bits 31 down to 0, one bit per MDC period.
- R2: While a frame runs, `mdc` has a period of CLK_DIV (default 32) system clocks, with CLK_DIV/2 high and CLK_DIV/2 low. `mdc` is low whenever the engine is idle.
- R3: `mdio_o` changes only in the clock cycle where `mdc` falls, or when a frame starts. Every bit is therefore stable across the rising MDC edge at which the PHY samples it.
- R4: For a read (bits 29:28 = 2'b10), `mdio_oe` is 1 for frame bits 0..46 and 0 from bit 47 (the second turnaround bit) to the end. The bits on `mdio_i` at the 16 rising MDC edges of bits 48..63 are stored MSB first in `word_q[15:0]`. `word_q[31:16]` keeps the written value.
- R5: For any other opcode, `mdio_oe` stays 1 for all 64 bits. `word_q` reads back exactly the written word.
- R6: `idle` falls in the cycle after an accepted write. It stays 0 for exactly 64*CLK_DIV cycles and then returns to 1. `mdio_oe` is 0 whenever `idle` is 1.
- R7: A write of the command word while a frame runs is ignored. The frame in flight, its timing and `word_q[31:16]` are unchanged, and no second frame follows.
- R8: With `port_en` low, writes are ignored and no MDC edges appear. Clearing `port_en` during a frame makes `idle` 1, `mdc` 0 and `mdio_oe` 0 one cycle later.
- R9: After reset `idle` is 1, `mdc` is 0, `mdio_oe` is 0 and `word_q` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| port_en | input | 1 | Management port enable |
| wr_en | input | 1 | Write strobe for the command word |
| wr_data | input | 32 | Command word to write |
| word_q | output | 32 | Command word readback; holds read data in bits 15:0 after a read |
| idle | output | 1 | 1 when no frame is in progress |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Management data driven toward the PHY |
| mdio_oe | output | 1 | Output enable for `mdio_o` (1 = drive) |
| mdio_i | input | 1 | Management data received from the PHY |

## Verification
Most faults in the bit counter or the opcode decode appear at the ports within one frame. A wrong counter misplaces preamble or header bits, shifts the point where the data line is released, or moves the return of the idle flag away from cycle 2048. A wrong capture point misaligns the 16 read-back bits in the low half of the word, which is visible as soon as that frame ends. A faulty divider shows in the very first MDC period, as a high or low time different from 16 cycles. A busy or enable gate that leaks shows as a second or unexpected frame, or as the word's upper half changing mid-frame.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int unsigned WORD_W    = 32;  // command word width
  localparam int unsigned DATA_W    = 16;  // data field width
  localparam int unsigned OP_HI_POS = 29;  // opcode field upper bit
  localparam int unsigned OP_LO_POS = 28;  // opcode field lower bit
  localparam int unsigned TA2_POS   = 16;  // second turnaround bit position

  typedef enum logic [1:0] {
    OP_NONE  = 2'b00,
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10,
    OP_BOTH  = 2'b11
  } mgmt_op_e;
endpackage

// File: rtl/mdio_clk_gen.sv
module mdio_clk_gen #(
  parameter int unsigned CLK_DIV = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic mdc,
  output logic rise_evt,
  output logic fall_evt
);
  localparam int unsigned CNT_W = $clog2(CLK_DIV);
  localparam int unsigned HALF  = CLK_DIV / 2;

  logic [CNT_W-1:0] cnt;

  // Events mark the system-clock edge at which mdc changes level.
  assign rise_evt = run && (cnt == CNT_W'(HALF - 1));
  assign fall_evt = run && (cnt == CNT_W'(CLK_DIV - 1));

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else begin
      cnt <= fall_evt ? '0 : cnt + 1'b1;
      if (rise_evt)
        mdc <= 1'b1;
      else if (fall_evt)
        mdc <= 1'b0;
    end
  end
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_pkg::*;
#(
  parameter int unsigned PRE_LEN = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              port_en,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              rise_evt,
  input  logic              fall_evt,
  input  logic              mdio_i,
  output logic              busy,
  output logic [WORD_W-1:0] word_q,
  output logic              mdio_o,
  output logic              mdio_oe
);
  localparam int unsigned TOTAL   = PRE_LEN + WORD_W;
  localparam int unsigned BC_W    = $clog2(TOTAL) + 1;
  localparam int unsigned IDX_W   = $clog2(WORD_W);
  localparam int unsigned REL_IDX = PRE_LEN + WORD_W - 1 - TA2_POS;
  localparam int unsigned CAP_IDX = PRE_LEN + WORD_W - DATA_W;
  localparam int unsigned LAST    = TOTAL - 1;

  logic [BC_W-1:0]  bit_cnt;
  logic [BC_W-1:0]  next_cnt;
  logic [BC_W-1:0]  word_off;
  logic [IDX_W-1:0] word_idx;
  logic             nxt_bit;
  logic             is_read;

  assign is_read  = (mgmt_op_e'(word_q[OP_HI_POS:OP_LO_POS]) == OP_READ);
  assign next_cnt = bit_cnt + 1'b1;
  assign word_off = next_cnt - BC_W'(PRE_LEN);
  assign word_idx = IDX_W'(WORD_W - 1) - word_off[IDX_W-1:0];

  // Preamble bits are ones; after that the word goes out MSB first.
  always_comb begin
    nxt_bit = 1'b1;
    if (next_cnt >= BC_W'(PRE_LEN))
      nxt_bit = word_q[word_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      bit_cnt <= '0;
      word_q  <= '0;
      mdio_o  <= 1'b1;
      mdio_oe <= 1'b0;
    end else if (!port_en) begin
      busy    <= 1'b0;
      bit_cnt <= '0;
      mdio_oe <= 1'b0;
    end else if (!busy) begin
      if (wr_en) begin
        busy    <= 1'b1;
        bit_cnt <= '0;
        word_q  <= wr_data;
        mdio_o  <= 1'b1;
        mdio_oe <= 1'b1;
      end
    end else begin
      if (rise_evt && is_read && (bit_cnt >= BC_W'(CAP_IDX)))
        word_q[DATA_W-1:0] <= {word_q[DATA_W-2:0], mdio_i};
      if (fall_evt) begin
        if (bit_cnt == BC_W'(LAST)) begin
          busy    <= 1'b0;
          mdio_oe <= 1'b0;
          mdio_o  <= 1'b1;
        end else begin
          bit_cnt <= next_cnt;
          mdio_o  <= nxt_bit;
          if (is_read && (next_cnt == BC_W'(REL_IDX)))
            mdio_oe <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine #(
  parameter int unsigned CLK_DIV = 32,
  parameter int unsigned PRE_LEN = 32
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        port_en,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] word_q,
  output logic        idle,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  logic busy;
  logic rise_evt;
  logic fall_evt;
  logic run;

  assign run  = busy && port_en;
  assign idle = !busy;

  mdio_clk_gen #(
    .CLK_DIV (CLK_DIV)
  ) i_clk_gen (
    .clk      (clk),
    .rst      (rst),
    .run      (run),
    .mdc      (mdc),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt)
  );

  mdio_frame_seq #(
    .PRE_LEN (PRE_LEN)
  ) i_seq (
    .clk      (clk),
    .rst      (rst),
    .port_en  (port_en),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt),
    .mdio_i   (mdio_i),
    .busy     (busy),
    .word_q   (word_q),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe)
  );
endmodule

// File: rtl/mdio_frame_engine_chk.sv
module mdio_frame_engine_chk (
  input logic        clk,
  input logic        rst,
  input logic        port_en,
  input logic        wr_en,
  input logic [31:0] word_q,
  input logic        idle,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe
);
  AST_OE_NEEDS_FRAME: assert property (@(posedge clk) disable iff (rst)
    mdio_oe |-> !idle); // R6

  AST_ACCEPT_STARTS: assert property (@(posedge clk) disable iff (rst)
    (idle && port_en && wr_en) |=> !idle); // R6

  AST_MDC_LOW_IDLE: assert property (@(posedge clk) disable iff (rst)
    idle |-> !mdc); // R2

  AST_MDIO_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    !$stable(mdio_o) |-> ($fell(mdc) || $fell(idle))); // R3

  AST_HDR_HELD: assert property (@(posedge clk) disable iff (rst)
    (!idle && $past(!idle)) |-> $stable(word_q[31:16])); // R7

  AST_DISABLE_STOPS: assert property (@(posedge clk) disable iff (rst)
    !port_en |=> (idle && !mdc && !mdio_oe)); // R8
endmodule

bind mdio_frame_engine mdio_frame_engine_chk i_chk (
  .clk     (clk),
  .rst     (rst),
  .port_en (port_en),
  .wr_en   (wr_en),
  .word_q  (word_q),
  .idle    (idle),
  .mdc     (mdc),
  .mdio_o  (mdio_o),
  .mdio_oe (mdio_oe)
);

// File: tb/test_mdio_frame_engine.sv
`timescale 1ns/1ps
module test_mdio_frame_engine;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        port_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] word_q;
  logic        idle, mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b0;

  int errors = 0;
  int checks = 0;

  typedef struct {
    logic [63:0] bits;
    logic [63:0] mask;
  } frame_t;
  frame_t exp_q[$];

  logic [63:0] got_b = '0;
  logic [63:0] got_m = '0;
  int          mon_k = 0;
  int          mdc_rises = 0;
  logic [15:0] phy_data = '0;
  logic        mdc_prev = 1'b0;
  int          run_len = 0;
  int          hi_len = 0;
  int          lo_len = 0;

  always #5 clk = ~clk;

  mdio_frame_engine i_mdio_frame_engine (
    .clk     (clk),
    .rst     (rst),
    .port_en (port_en),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .word_q  (word_q),
    .idle    (idle),
    .mdc     (mdc),
    .mdio_o  (mdio_o),
    .mdio_oe (mdio_oe),
    .mdio_i  (mdio_i)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_word(input logic [1:0] op, input logic [4:0] phy,
                                          input logic [4:0] rg, input logic [15:0] dat);
    return {2'b01, op, phy, rg, 2'b10, dat};
  endfunction

  // Monitor: PHY-side sampling at rising MDC, compared against the scoreboard.
  always @(posedge mdc) begin
    mdc_rises++;
    got_b = {got_b[62:0], mdio_o};
    got_m = {got_m[62:0], mdio_oe};
    mon_k++;
    if (mon_k == 64) begin
      mon_k = 0;
      if (exp_q.size() == 0) begin
        chk(1'b0, "R7 unexpected frame", got_b, 64'h0);
      end else begin
        frame_t e;
        e = exp_q.pop_front();
        chk((got_b & e.mask) == (e.bits & e.mask), "R1 frame bits", got_b, e.bits);
        chk(got_m == e.mask, "R4/R5 oe pattern (R4 R5)", got_m, e.mask);
      end
    end
  end

  // PHY model: drives read data after the falling MDC edge.
  always @(negedge mdc) begin
    if (mon_k >= 48 && mon_k < 64)
      mdio_i = phy_data[63 - mon_k];
    else
      mdio_i = 1'b0;
  end

  // MDC run-length measurement.
  always @(negedge clk) begin
    if (mdc && !mdc_prev) begin
      lo_len = run_len;
      run_len = 1;
    end else if (!mdc && mdc_prev) begin
      hi_len = run_len;
      run_len = 1;
    end else begin
      run_len++;
    end
    mdc_prev = mdc;
  end

  task automatic push_exp(input logic [31:0] w);
    frame_t f;
    f.bits = {32'hFFFF_FFFF, w};
    f.mask = (w[29:28] == 2'b10) ? 64'hFFFF_FFFF_FFFE_0000 : 64'hFFFF_FFFF_FFFF_FFFF;
    exp_q.push_back(f);
  endtask

  task automatic pulse_write(input logic [31:0] w);
    @(negedge clk);
    wr_data = w;
    wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_done(output int n);
    n = 0;
    while (idle == 1'b0 && n < 5000) begin
      @(negedge clk);
      n++;
    end
    if (n >= 5000) chk(1'b0, "R6 frame never ended", 64'(n), 64'd2048);
  endtask

  task automatic run_frame(input logic [31:0] w, input logic [15:0] pd);
    int n;
    logic [31:0] exp_w;
    phy_data = pd;
    push_exp(w);
    pulse_write(w);
    chk(idle == 1'b0, "R6 idle low after accept", 64'(idle), 64'd0);
    wait_done(n);
    chk(n == 2048, "R6 frame length", 64'(n), 64'd2048);
    chk(hi_len == 16 && lo_len == 16, "R2 mdc high/low time", 64'({hi_len[15:0], lo_len[15:0]}), 64'h0010_0010);
    exp_w = (w[29:28] == 2'b10) ? {w[31:16], pd} : w;
    chk(word_q == exp_w, (w[29:28] == 2'b10) ? "R4 read data in word" : "R5 write word readback",
        64'(word_q), 64'(exp_w));
    chk(exp_q.size() == 0, "R1 frame consumed by monitor", 64'(exp_q.size()), 64'd0);
    chk(mdc == 1'b0 && mdio_oe == 1'b0, "R2 mdc low and line released when idle",
        64'({mdc, mdio_oe}), 64'd0);
  endtask

  initial begin
    #2_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int n;
    int rises0;
    logic [31:0] w0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    chk(idle == 1'b1, "R9 idle after reset", 64'(idle), 64'd1);
    chk(mdc == 1'b0, "R9 mdc after reset", 64'(mdc), 64'd0);
    chk(mdio_oe == 1'b0, "R9 oe after reset", 64'(mdio_oe), 64'd0);
    chk(word_q == 32'h0, "R9 word after reset", 64'(word_q), 64'd0);

    port_en = 1'b1;
    repeat (3) @(negedge clk);

    // R1 R5 write frames, two data patterns
    run_frame(mk_word(2'b01, 5'h0A, 5'h03, 16'hA5C3), 16'h0000);
    run_frame(mk_word(2'b01, 5'h1F, 5'h00, 16'h0001), 16'h0000);
    // R4 read frames, distinct return patterns
    run_frame(mk_word(2'b10, 5'h01, 5'h02, 16'h0000), 16'h3C96);
    run_frame(mk_word(2'b10, 5'h15, 5'h1F, 16'h0000), 16'h8001);
    run_frame(mk_word(2'b10, 5'h00, 5'h11, 16'hFFFF), 16'h0000);

    // R7 write during a frame is ignored
    w0 = mk_word(2'b01, 5'h05, 5'h0C, 16'h1234);
    push_exp(w0);
    pulse_write(w0);
    repeat (100) @(negedge clk);
    pulse_write(mk_word(2'b10, 5'h1A, 5'h1B, 16'hDEAD));
    wait_done(n);
    chk(n == 1946, "R7 busy write leaves timing unchanged", 64'(n), 64'd1946);
    chk(word_q == w0, "R7 busy write ignored", 64'(word_q), 64'(w0));
    repeat (200) @(negedge clk);
    chk(idle == 1'b1 && exp_q.size() == 0, "R7 no second frame", 64'({idle, exp_q.size() == 0}), 64'h3);

    // R8 write with the port disabled is ignored
    port_en = 1'b0;
    rises0 = mdc_rises;
    pulse_write(mk_word(2'b01, 5'h02, 5'h02, 16'h5555));
    repeat (100) @(negedge clk);
    chk(idle == 1'b1 && mdc_rises == rises0, "R8 disabled write ignored",
        64'({idle, mdc_rises[15:0]}), 64'({1'b1, rises0[15:0]}));
    chk(word_q == w0, "R8 disabled write leaves word", 64'(word_q), 64'(w0));

    // R8 clearing enable mid-frame aborts it
    port_en = 1'b1;
    @(negedge clk);
    pulse_write(mk_word(2'b01, 5'h07, 5'h08, 16'h0F0F));
    repeat (300) @(negedge clk);
    port_en = 1'b0;
    @(negedge clk);
    chk(idle == 1'b1 && mdc == 1'b0 && mdio_oe == 1'b0, "R8 abort returns to idle",
        64'({idle, mdc, mdio_oe}), 64'h4);
    mon_k = 0;
    rises0 = mdc_rises;
    repeat (100) @(negedge clk);
    chk(mdc_rises == rises0, "R8 no mdc after abort", 64'(mdc_rises), 64'(rises0));

    // R3 frame after abort is clean again
    port_en = 1'b1;
    @(negedge clk);
    run_frame(mk_word(2'b01, 5'h11, 5'h04, 16'hC0DE), 16'h0000);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule